// File: doc/BRIEF.md
# Iterative Byte-Matrix Permutation Core

This block runs one of two fixed 512-bit permutations over a state arranged as an 8 by 8 matrix of bytes. It is meant as the engine inside a wide-pipe compression function. The caller presents a state and a one-bit variant select, then pulses a start input. The core then applies one full round per clock for ten rounds, pulses done, and presents the permuted state on a registered output. The output holds that value until the next permutation finishes.

Each round has four steps in a fixed order. First a constant is XORed into the state. Second, every byte passes through the AES substitution box. Third, each row is rotated left by a number of byte positions that depends on the row. Fourth, every column is multiplied by a fixed circulant matrix over GF(2^8), using the reduction polynomial 0x11B. The two variants differ only in the constant step and in the rotation amounts.

Byte layout on both state ports: row r, column c occupies bits [8*(8*c+r)+7 : 8*(8*c+r)]. Column 0, row 0 is therefore the least significant byte, and each column is eight consecutive bytes.

Top module: `grp_perm_core`

## Requirements
- R1: While reset is asserted and after its release, done is 0 and out_state is all zeros until the first permutation finishes.
- R2: A start accepted at a clock edge makes done go to 1 exactly 10 edges later. Done stays high for exactly one cycle.
- R3: With mode 0 (variant A), round k (k = 0..9) XORs the byte {c[3:0], k[3:0]} into row 0, column c. No other byte is altered by the constant step.
- R4: With mode 1 (variant B), round k XORs 0xFF into every byte. It also XORs {c[3:0], k[3:0]} into row 7, column c.
- R5: The substitution step maps each byte through the AES S-box, for example 0x00 to 0x63, 0x01 to 0x7C and 0x53 to 0xED.
- R6: The rotation step moves row r left so that new[r][c] = old[r][(c+s[r]) mod 8]. For variant A, s = {0,1,2,3,4,5,6,7} for rows 0..7. For variant B, s = {1,3,5,7,0,2,4,6}.
- R7: The mixing step sets b[i] = XOR over j of m[(j-i) mod 8] * a[j] for each column, with m = {2,2,3,4,5,3,5,7}.
- R8: When done is 1, out_state equals the input state after ten rounds of constant, substitution, rotation and mixing, applied in that order.
- R9: The mode value is captured at the accepted start. Changes to mode during the run do not affect the result.
- R10: A start while a permutation is running is ignored. The running result and its timing are unchanged, and no extra done pulse follows.
- R11: out_state holds its value in every cycle in which done is 0, whatever start, mode and in_state do without an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a permutation when idle |
| mode | input | 1 | Variant select: 0 = A, 1 = B |
| in_state | input | 512 | State to permute, layout as above |
| done | output | 1 | One-cycle pulse when the result is ready |
| out_state | output | 512 | Registered permuted state |

## Verification
The bench drives start at a falling edge, so it is taken at the next rising edge (edge N). The result and the done pulse are due at edge N+10. The bench samples ten falling edges later and checks that done was low at every earlier sample. It checks again one falling edge after the result that the pulse has ended. The expected states come from a reference model in the bench. That model builds its S-box with a generator walk and uses generic polynomial multiplication. For the ignored-start and hold cases, the bench watches done and out_state for fixed windows of falling edges after the result, so that any late or extra effect is seen.

// File: rtl/grp_pkg.sv
`timescale 1ns/1ps
package grp_pkg;

   localparam int ROWS    = 8;
   localparam int COLS    = 8;
   localparam int BYTE_W  = 8;
   localparam int STATE_W = ROWS * COLS * BYTE_W;
   localparam int RC_W    = 4;   // round index width inside the constant byte

   typedef logic [BYTE_W-1:0] byte_t;
   typedef byte_t [ROWS-1:0][COLS-1:0] mat_t;   // [row][column]
   typedef byte_t [ROWS-1:0] col_t;
   typedef byte_t [255:0] rom_t;

   typedef enum logic {PERM_A = 1'b0, PERM_B = 1'b1} perm_e;

   function automatic byte_t gf_dbl(byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic byte_t gf_mul(byte_t a, byte_t b);
      byte_t acc;
      byte_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < BYTE_W; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_dbl(sh);
      end
      return acc;
   endfunction

   // x^254 gives the multiplicative inverse, 0 maps to 0
   function automatic byte_t gf_inv(byte_t x);
      byte_t x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
      x2   = gf_mul(x, x);
      x3   = gf_mul(x2, x);
      x6   = gf_mul(x3, x3);
      x12  = gf_mul(x6, x6);
      x15  = gf_mul(x12, x3);
      x30  = gf_mul(x15, x15);
      x60  = gf_mul(x30, x30);
      x120 = gf_mul(x60, x60);
      x240 = gf_mul(x120, x120);
      x252 = gf_mul(x240, x12);
      return gf_mul(x252, x2);
   endfunction

   function automatic byte_t sbox_calc(byte_t x);
      byte_t b;
      b = gf_inv(x);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

   function automatic rom_t build_rom();
      rom_t t;
      for (int i = 0; i < 256; i++) t[i] = sbox_calc(byte_t'(i));
      return t;
   endfunction

   // multiply by one of the small constants used in the mixing matrix
   function automatic byte_t mul_const(int k, byte_t a);
      byte_t m2, m4;
      m2 = gf_dbl(a);
      m4 = gf_dbl(m2);
      case (k)
         2:       return m2;
         3:       return m2 ^ a;
         4:       return m4;
         5:       return m4 ^ a;
         7:       return m4 ^ m2 ^ a;
         default: return a;
      endcase
   endfunction

   function automatic int mix_coef(int d);
      case (d)
         0, 1:    return 2;
         2, 5:    return 3;
         3:       return 4;
         4, 6:    return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int row_rot(perm_e m, int r);
      if (m == PERM_A) return r;
      case (r)
         0:       return 1;
         1:       return 3;
         2:       return 5;
         3:       return 7;
         4:       return 0;
         5:       return 2;
         6:       return 4;
         default: return 6;
      endcase
   endfunction

   function automatic mat_t to_mat(logic [STATE_W-1:0] v);
      mat_t m;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            m[r][c] = v[BYTE_W*(ROWS*c+r) +: BYTE_W];
      return m;
   endfunction

   function automatic logic [STATE_W-1:0] from_mat(mat_t m);
      logic [STATE_W-1:0] v;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            v[BYTE_W*(ROWS*c+r) +: BYTE_W] = m[r][c];
      return v;
   endfunction

endpackage

// File: rtl/grp_sub_layer.sv
`timescale 1ns/1ps
module grp_sub_layer import grp_pkg::*; #(
   parameter int SBOX_IMPL = 0   // 0: inversion logic per byte, 1: computed lookup table
) (
   input  mat_t d_i,
   output mat_t d_o
);
   generate
      if (SBOX_IMPL == 0) begin : g_logic
         always_comb begin
            for (int r = 0; r < ROWS; r++)
               for (int c = 0; c < COLS; c++)
                  d_o[r][c] = sbox_calc(d_i[r][c]);
         end
      end else begin : g_table
         localparam rom_t LUT = build_rom();
         always_comb begin
            for (int r = 0; r < ROWS; r++)
               for (int c = 0; c < COLS; c++)
                  d_o[r][c] = LUT[d_i[r][c]];
         end
      end
   endgenerate
endmodule

// File: rtl/grp_mix_column.sv
`timescale 1ns/1ps
module grp_mix_column import grp_pkg::*; (
   input  col_t col_i,
   output col_t col_o
);
   always_comb begin
      for (int i = 0; i < ROWS; i++) begin
         col_o[i] = '0;
         for (int j = 0; j < ROWS; j++)
            col_o[i] = col_o[i] ^ mul_const(mix_coef((j - i + ROWS) % ROWS), col_i[j]);
      end
   end
endmodule

// File: rtl/grp_round.sv
`timescale 1ns/1ps
module grp_round import grp_pkg::*; #(
   parameter int SBOX_IMPL = 0
) (
   input  mat_t            st_i,
   input  perm_e           mode_i,
   input  logic [RC_W-1:0] rnd_i,
   output mat_t            st_o
);
   mat_t arc, sub, shf;
   wire [COLS-1:0][ROWS-1:0][BYTE_W-1:0] mixed;

   // constant step
   always_comb begin
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            arc[r][c] = st_i[r][c];
            if (mode_i == PERM_B) arc[r][c] = arc[r][c] ^ 8'hff;
            if ((mode_i == PERM_A && r == 0) || (mode_i == PERM_B && r == ROWS-1))
               arc[r][c] = arc[r][c] ^ {4'(c), rnd_i};
         end
      end
   end

   grp_sub_layer #(.SBOX_IMPL(SBOX_IMPL)) u_sub (
      .d_i (arc),
      .d_o (sub)
   );

   // rotation step
   always_comb begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            shf[r][c] = sub[r][(c + row_rot(mode_i, r)) % COLS];
   end

   // mixing step, one instance per column
   genvar gc;
   generate
      for (gc = 0; gc < COLS; gc++) begin : g_col
         col_t cin;
         always_comb begin
            for (int r = 0; r < ROWS; r++) cin[r] = shf[r][gc];
         end
         grp_mix_column u_mix (
            .col_i (cin),
            .col_o (mixed[gc])
         );
      end
   endgenerate

   always_comb begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            st_o[r][c] = mixed[c][r];
   end
endmodule

// File: rtl/grp_ctrl.sv
`timescale 1ns/1ps
module grp_ctrl #(
   parameter int NUM_ROUNDS = 10,
   parameter int RND_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_o,
   output logic             step_o,
   output logic             last_o,
   output logic             busy_o,
   output logic [RND_W-1:0] rnd_o,
   output logic             done_o
);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

   assign load_o = start_i && !busy_o;
   assign step_o = busy_o;
   assign last_o = busy_o && (rnd_o == LAST_RND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         rnd_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               busy_o <= 1'b1;
               rnd_o  <= '0;
            end
         end else if (rnd_o == LAST_RND) begin
            busy_o <= 1'b0;
            rnd_o  <= '0;
            done_o <= 1'b1;
         end else begin
            rnd_o <= rnd_o + 1'b1;
         end
      end
   end
endmodule

// File: rtl/grp_perm_core.sv
`timescale 1ns/1ps
module grp_perm_core import grp_pkg::*; #(
   parameter int NUM_ROUNDS = 10,
   parameter int SBOX_IMPL  = 0,
   localparam int RND_W     = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               mode,
   input  logic [STATE_W-1:0] in_state,
   output logic               done,
   output logic [STATE_W-1:0] out_state
);
   generate
      if (NUM_ROUNDS < 1 || NUM_ROUNDS > (1 << RC_W)) begin : g_bad_rounds
         $error("NUM_ROUNDS must lie in 1..16");
      end
      if (SBOX_IMPL != 0 && SBOX_IMPL != 1) begin : g_bad_sbox
         $error("SBOX_IMPL must be 0 or 1");
      end
   endgenerate

   logic             load, step, last, busy;
   logic [RND_W-1:0] rnd_q;
   perm_e            mode_q;
   mat_t             st_q, st_nxt;

   grp_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .RND_W(RND_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .load_o  (load),
      .step_o  (step),
      .last_o  (last),
      .busy_o  (busy),
      .rnd_o   (rnd_q),
      .done_o  (done)
   );

   grp_round #(.SBOX_IMPL(SBOX_IMPL)) u_round (
      .st_i   (st_q),
      .mode_i (mode_q),
      .rnd_i  (RC_W'(rnd_q)),
      .st_o   (st_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         mode_q <= PERM_A;
      end else if (load) begin
         st_q   <= to_mat(in_state);
         mode_q <= perm_e'(mode);
      end else if (step) begin
         st_q   <= st_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_state <= '0;
      else if (last) out_state <= from_mat(st_nxt);
   end
endmodule

// File: rtl/grp_perm_checker.sv
`timescale 1ns/1ps
module grp_perm_checker import grp_pkg::*; #(
   parameter int NUM_ROUNDS = 10,
   parameter int RND_W      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               done,
   input logic [STATE_W-1:0] out_state,
   input logic               busy,
   input perm_e              mode_q,
   input logic [RND_W-1:0]   rnd_q
);
   localparam int CNT_W = $clog2(NUM_ROUNDS + 2);
   localparam logic [CNT_W-1:0] DUE = CNT_W'(NUM_ROUNDS + 1);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cnt <= '0;
      else if (start && !busy)                      cnt <= CNT_W'(1);
      else if (cnt != '0 && cnt < DUE)              cnt <= cnt + 1'b1;
      else                                          cnt <= '0;
   end

   p_done_on_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cnt == DUE));

   p_done_not_missed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == DUE) |-> done);

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(out_state));

   p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q));

   p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && rnd_q != LAST_RND) |=> (busy && rnd_q == $past(rnd_q) + 1'b1));

   p_round_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_q <= LAST_RND);
endmodule

bind grp_perm_core grp_perm_checker #(.NUM_ROUNDS(NUM_ROUNDS), .RND_W(RND_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .out_state (out_state),
   .busy      (busy),
   .mode_q    (mode_q),
   .rnd_q     (rnd_q)
);

// File: tb/grp_perm_core_bench.sv
`timescale 1ns/1ps
module grp_perm_core_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         mode = 1'b0;
   logic [511:0] in_state = '0;
   logic         done;
   logic [511:0] out_state;

   int checks = 0;
   int errors = 0;
   logic [7:0] sb [256];
   logic [7:0] gp, gq;

   always #5 clk = ~clk;

   grp_perm_core u_grp_perm_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .in_state  (in_state),
      .done      (done),
      .out_state (out_state)
   );

   task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rotl8(logic [7:0] v, int k);
      return (v << k) | (v >> (8 - k));
   endfunction

   function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011b << (k - 8));
      return p[7:0];
   endfunction

   function automatic int ref_rot(bit q, int r);
      int tb[8];
      tb = '{1, 3, 5, 7, 0, 2, 4, 6};
      return q ? tb[r] : r;
   endfunction

   // reference permutation, built from the requirements R3..R8
   function automatic logic [511:0] model(input logic [511:0] s, input bit q);
      logic [7:0] m [8][8];
      logic [7:0] t [8][8];
      logic [7:0] acc;
      logic [511:0] o;
      int coef[8];
      coef = '{2, 2, 3, 4, 5, 3, 5, 7};
      for (int c = 0; c < 8; c++) for (int r = 0; r < 8; r++) m[r][c] = s[8*(8*c+r) +: 8];
      for (int k = 0; k < 10; k++) begin
         for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) begin
            if (q) m[r][c] = m[r][c] ^ 8'hff;
            if ((!q && r == 0) || (q && r == 7)) m[r][c] = m[r][c] ^ {4'(c), 4'(k)};
            m[r][c] = sb[m[r][c]];
         end
         for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++)
            t[r][c] = m[r][(c + ref_rot(q, r)) % 8];
         for (int c = 0; c < 8; c++) for (int i = 0; i < 8; i++) begin
            acc = '0;
            for (int j = 0; j < 8; j++) acc = acc ^ ref_mul(8'(coef[(j - i + 8) % 8]), t[j][c]);
            m[i][c] = acc;
         end
      end
      for (int c = 0; c < 8; c++) for (int r = 0; r < 8; r++) o[8*(8*c+r) +: 8] = m[r][c];
      return o;
   endfunction

   function automatic logic [511:0] rand_state();
      logic [511:0] v;
      for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   // one permutation; inj>0 pulses a second start at that cycle, flip changes mode after start
   task automatic run_perm(input logic [511:0] din, input bit q, input int inj, input bit flip,
                           input string req);
      logic [511:0] exp;
      bit early;
      exp = model(din, q);
      early = 1'b0;
      @(negedge clk); in_state = din; mode = q; start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (flip) mode = ~q;
      for (int k = 1; k <= 10; k++) begin
         if (k == inj) begin in_state = ~din; mode = ~q; start = 1'b1; end
         @(negedge clk);
         start = 1'b0;
         if (k < 10 && done) early = 1'b1;
      end
      chk(!early, {req, " R2 done before round ten"}, 512'(early), 512'(0));
      chk(done === 1'b1, {req, " R2 done due"}, 512'(done), 512'(1));
      chk(out_state === exp, {req, " R8 result"}, out_state, exp);
      @(negedge clk);
      chk(done === 1'b0, {req, " R2 single pulse"}, 512'(done), 512'(0));
   endtask

   task automatic t_reset();
      chk(done === 1'b0, "R1 done at reset", 512'(done), 512'(0));
      chk(out_state === '0, "R1 out at reset", out_state, '0);
      chk(sb[8'h00] == 8'h63 && sb[8'h01] == 8'h7c && sb[8'h53] == 8'hed, "R5 model sbox",
          {sb[8'h00], sb[8'h01], sb[8'h53]}, 512'h637ced);
   endtask

   task automatic t_ignore_and_hold();
      logic [511:0] held;
      bit extra;
      run_perm(rand_state(), 1'b1, 4, 1'b0, "R10 busy start");
      held = out_state;
      extra = 1'b0;
      for (int k = 0; k < 14; k++) begin
         in_state = rand_state(); mode = k[0];
         @(negedge clk);
         if (done) extra = 1'b1;
      end
      chk(!extra, "R10 no extra done", 512'(extra), 512'(0));
      chk(out_state === held, "R11 output held", out_state, held);
   endtask

   initial begin
      gp = 8'h01; gq = 8'h01;
      do begin
         gp = gp ^ {gp[6:0], 1'b0} ^ (gp[7] ? 8'h1b : 8'h00);
         gq = gq ^ {gq[6:0], 1'b0};
         gq = gq ^ {gq[5:0], 2'b00};
         gq = gq ^ {gq[3:0], 4'h0};
         if (gq[7]) gq = gq ^ 8'h09;
         sb[gp] = gq ^ rotl8(gq, 1) ^ rotl8(gq, 2) ^ rotl8(gq, 3) ^ rotl8(gq, 4) ^ 8'h63;
      end while (gp != 8'h01);
      sb[0] = 8'h63;

      #1;
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      run_perm('0, 1'b0, 0, 1'b0, "R3 R5 zero state A");
      run_perm('0, 1'b1, 0, 1'b0, "R4 R5 zero state B");
      begin
         logic [511:0] cnt_pat;
         for (int i = 0; i < 64; i++) cnt_pat[8*i +: 8] = 8'(i);
         run_perm(cnt_pat, 1'b0, 0, 1'b0, "R6 R7 counting A");
         run_perm(cnt_pat, 1'b1, 0, 1'b0, "R6 R7 counting B");
      end
      run_perm(512'h1 << 200, 1'b0, 0, 1'b0, "R7 single bit A");
      run_perm('1, 1'b1, 0, 1'b0, "R4 all ones B");
      run_perm(rand_state(), 1'b0, 0, 1'b1, "R9 mode change A");
      run_perm(rand_state(), 1'b1, 0, 1'b1, "R9 mode change B");
      t_ignore_and_hold();
      run_perm(rand_state(), 1'b0, 9, 1'b0, "R10 late start");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule